// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-programmed supervisory timer. A prescaler divides the system clock into a slow tick, nominally one tick every 0.6 s. A timeout of S seconds therefore needs S*10/6 ticks. A 10-bit down-counter is loaded from a software-programmed start value and decrements once per tick while the halt bit in the control register is clear. Software keeps the system alive by writing the reload key, which puts the start value back into the counter.

Expiry has two stages:

- **First expiry.** The counter reloads itself and raises a timeout flag, but nothing else happens.
- **Second expiry.** If the counter runs out again while that flag is still set, a second-timeout flag is latched. The reset request output then asserts, unless the no-reboot inhibit bit is set.
- **Further expiry.** An expiry while the second-timeout flag is already set also latches a boot-status flag.

All flags are write-1-to-clear. Access is through a simple byte-addressed 16-bit register bus with registered read data.

Top module: `twostage_wdt`

## Requirements
- R1: After reset the control register reads 0x0800 (halted), the inhibit register reads 1, both status registers read 0, the start-value register and the count read 50, and `reset_req` is 0.
- R2: While running, the count decrements once every TICK_CYCLES clocks. An expiry occurs exactly start-value × TICK_CYCLES clock edges after the edge that un-halts the timer or accepts a reload.
- R3: Bit 11 of the control register (offset 0x08) halts both the counter and the prescaler when 1. The whole control register reads back as written.
- R4: A write of exactly 0x0001 to offset 0x00 loads the start value and restarts the prescaler, and any other value written there is ignored. A read of offset 0x00 returns the count in bits [9:0] with zeros above.
- R5: The start-value register (offset 0x12) stores all 16 bits written, and the counter uses bits [9:0]. A write whose low field is 0 to 3 is ignored entirely. A write does not change the running count.
- R6: The first expiry sets bit 3 of the first status register (offset 0x04), and on the same edge the count returns to the start value.
- R7: Writing 1 to bit 3 of offset 0x04 clears the timeout flag. Writing 0 there leaves it unchanged.
- R8: An expiry while the timeout flag is set latches bit 1 of the second status register (offset 0x06), which is write-1-to-clear.
- R9: `reset_req` is 1 from the edge after the second-timeout flag is set and the inhibit bit (offset 0x0C, bit 0, readable) is 0. It falls one edge after either condition ends.
- R10: An expiry while the second-timeout flag is already set latches bit 2 of offset 0x06, which is write-1-to-clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| reset_req | output | 1 | Registered system reset request |

## Verification
- **Register writes.** A write takes effect on the edge that samples the strobe.
- **Register reads.** Read data reflects the state after edge t when the strobe is presented in the cycle following t. The bench therefore issues every read keyed to an absolute edge number taken from its own cycle counter.
- **Expiry timing.** Expiry times are computed from the edge that un-halts or reloads, as start value × TICK_CYCLES. The status register is sampled one edge before that point and on that exact edge, so an off-by-one shows up.
- **Reset request.** `reset_req` has one register stage. It is checked both on the edge where the inhibit or flag changes, where it must still hold its old value, and on the following edge.

// File: rtl/twostage_wdt_pkg.sv
package twostage_wdt_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_RELOAD  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT_A  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT_B  = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_INHIBIT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_START   = 5'h12;

  localparam int BIT_HALT    = 11;
  localparam int BIT_TMO     = 3;
  localparam int BIT_SECOND  = 1;
  localparam int BIT_BOOT    = 2;
  localparam int START_MIN   = 4;
  localparam logic [15:0] RELOAD_KEY = 16'h0001;
endpackage

// File: rtl/twostage_wdt_prescale.sv
module twostage_wdt_prescale #(
  parameter int TICK_CYCLES = 30_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (TICK_CYCLES <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      localparam int PW = $clog2(TICK_CYCLES);
      localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);
      logic [PW-1:0] div_q;

      always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
          div_q <= '0;
        end else if (div_q == LAST) begin
          div_q <= '0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end

      assign tick = run && (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/twostage_wdt_counter.sv
module twostage_wdt_counter #(
  parameter int CNT_W     = 10,
  parameter int RST_COUNT = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = tick && !reload && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(RST_COUNT);
    end else if (reload || expire) begin
      cnt_q <= start_val;
    end else if (tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/twostage_wdt_regs.sv
module twostage_wdt_regs
  import twostage_wdt_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 10,
  parameter int START_RST = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic              halt,
  output logic              inhibit,
  output logic [CNT_W-1:0]  start_val,
  output logic              reload_req,
  output logic              sec_flag
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] start_q;
  logic              inhibit_q;
  logic              tmo_q;
  logic              sec_q;
  logic              boot_q;
  logic [DATA_W-1:0] rdata_q;

  logic wr_ctrl, wr_start, wr_inh, wr_sa, wr_sb;

  assign wr_ctrl  = wr && (addr == OFS_CTRL);
  assign wr_start = wr && (addr == OFS_START);
  assign wr_inh   = wr && (addr == OFS_INHIBIT);
  assign wr_sa    = wr && (addr == OFS_STAT_A);
  assign wr_sb    = wr && (addr == OFS_STAT_B);
  assign reload_req = wr && (addr == OFS_RELOAD) && (wdata == DATA_W'(RELOAD_KEY));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= DATA_W'(1) << BIT_HALT;
      start_q   <= DATA_W'(START_RST);
      inhibit_q <= 1'b1;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_start && (wdata[CNT_W-1:0] >= CNT_W'(START_MIN))) start_q <= wdata;
      if (wr_inh) inhibit_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q  <= 1'b0;
      sec_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      if (expire && !tmo_q)              tmo_q <= 1'b1;
      else if (wr_sa && wdata[BIT_TMO])  tmo_q <= 1'b0;

      if (expire && tmo_q)                  sec_q <= 1'b1;
      else if (wr_sb && wdata[BIT_SECOND])  sec_q <= 1'b0;

      if (expire && tmo_q && sec_q)       boot_q <= 1'b1;
      else if (wr_sb && wdata[BIT_BOOT])  boot_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      case (addr)
        OFS_RELOAD:  rdata_q <= {{PAD_W{1'b0}}, count};
        OFS_STAT_A:  rdata_q <= DATA_W'(tmo_q) << BIT_TMO;
        OFS_STAT_B:  rdata_q <= (DATA_W'(sec_q) << BIT_SECOND) | (DATA_W'(boot_q) << BIT_BOOT);
        OFS_CTRL:    rdata_q <= ctrl_q;
        OFS_INHIBIT: rdata_q <= DATA_W'(inhibit_q);
        OFS_START:   rdata_q <= start_q;
        default:     rdata_q <= '0;
      endcase
    end
  end

  assign rdata     = rdata_q;
  assign halt      = ctrl_q[BIT_HALT];
  assign inhibit   = inhibit_q;
  assign start_val = start_q[CNT_W-1:0];
  assign sec_flag  = sec_q;
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import twostage_wdt_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int TICK_CYCLES = (CLK_HZ / 10) * 6,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 10,
  parameter int START_RST   = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);
  logic             halt, inhibit, reload_req, sec_flag, tick, expire;
  logic [CNT_W-1:0] start_val, cnt_q;
  logic             reset_req_q;

  twostage_wdt_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .START_RST(START_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .rdata(bus_rdata), .count(cnt_q), .expire(expire),
    .halt(halt), .inhibit(inhibit), .start_val(start_val),
    .reload_req(reload_req), .sec_flag(sec_flag)
  );

  twostage_wdt_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk(clk), .rst(rst), .run(!halt), .restart(reload_req), .tick(tick)
  );

  twostage_wdt_counter #(.CNT_W(CNT_W), .RST_COUNT(START_RST)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .reload(reload_req),
    .start_val(start_val), .count(cnt_q), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) reset_req_q <= 1'b0;
    else     reset_req_q <= sec_flag && !inhibit;
  end

  assign reset_req = reset_req_q;
endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] start_val,
  input logic             tick,
  input logic             expire,
  input logic             reload,
  input logic             halt,
  input logic             inhibit,
  input logic             tmo,
  input logic             sec,
  input logic             boot,
  input logic             reset_req
);
  // R2
  count_only_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !reload) |=> $stable(count));
  // R3
  halt_freezes_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !reload) |=> $stable(count));
  // R5
  start_floor_chk: assert property (@(posedge clk) disable iff (rst)
    start_val >= CNT_W'(4));
  // R6
  expire_reloads_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (count == $past(start_val)));
  // R8
  second_after_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sec) |-> $past(tmo));
  // R9
  inhibit_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(!inhibit && sec));
  // R10
  boot_after_second_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(boot) |-> $past(sec));
endmodule

bind twostage_wdt twostage_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .count(cnt_q), .start_val(start_val), .tick(tick),
  .expire(expire), .reload(reload_req), .halt(halt), .inhibit(inhibit),
  .tmo(u_regs.tmo_q), .sec(sec_flag), .boot(u_regs.boot_q),
  .reset_req(reset_req)
);

// File: tb/twostage_wdt_bench.sv
module twostage_wdt_bench;
  localparam int TC = 4;
  localparam logic [4:0] A_RLD = 5'h00, A_SA = 5'h04, A_SB = 5'h06,
                         A_CTL = 5'h08, A_INH = 5'h0C, A_ST = 5'h12;

  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic reset_req;
  int cyc = 0;
  int checks = 0, failures = 0;

  twostage_wdt #(.TICK_CYCLES(TC)) u_twostage_wdt (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .reset_req(reset_req)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d, output int e);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 e = cyc;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_at(int t, logic [4:0] a, output logic [15:0] v);
    while (cyc < t) @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    v = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic port_at(int t, string req, int exp);
    while (cyc < t) @(negedge clk);
    check(req, int'(reset_req), exp);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 reset_req", int'(reset_req), 0);
    rd_at(cyc, A_CTL, v); check("R1 ctrl", v, 16'h0800);
    rd_at(cyc, A_INH, v); check("R1 inhibit", v, 1);
    rd_at(cyc, A_SA, v);  check("R1 status A", v, 0);
    rd_at(cyc, A_SB, v);  check("R1 status B", v, 0);
    rd_at(cyc, A_ST, v);  check("R1 start value", v, 50);
    rd_at(cyc, A_RLD, v); check("R1 count", v, 50);
  endtask

  task automatic t_config();
    logic [15:0] v, c1; int e;
    wr(A_ST, 16'h0002, e); rd_at(e, A_ST, v); check("R5 start 2 ignored", v, 50);
    wr(A_ST, 16'hFC03, e); rd_at(e, A_ST, v); check("R5 start 3 ignored", v, 50);
    wr(A_ST, 16'hFC05, e); rd_at(e, A_ST, v); check("R5 start all bits stored", v, 16'hFC05);
    rd_at(e, A_RLD, v); check("R5 count untouched by start write", v, 50);
    wr(A_CTL, 16'h8800, e); rd_at(e, A_CTL, v); check("R3 ctrl readback", v, 16'h8800);
    wr(A_RLD, 16'h0001, e); rd_at(e, A_RLD, c1); check("R4 reload key loads start", c1, 5);
    rd_at(e + 30, A_RLD, v); check("R3 halted count frozen", v, 5);
  endtask

  task automatic t_two_stage();
    logic [15:0] v; int e0, e, en, es, eh;
    wr(A_CTL, 16'h0000, e0);
    rd_at(e0 + 8, A_RLD, v);  check("R2 two ticks elapsed", v, 3);
    rd_at(e0 + 19, A_SA, v);  check("R6 no expiry one edge early", v, 0);
    rd_at(e0 + 20, A_SA, v);  check("R6 first expiry flag", v, 16'h0008);
    rd_at(e0 + 21, A_RLD, v); check("R6 count reloaded on expiry", v, 5);
    wr(A_SA, 16'h0000, e); rd_at(e, A_SA, v); check("R7 write 0 keeps flag", v, 16'h0008);
    wr(A_SA, 16'h0008, e); rd_at(e, A_SA, v); check("R7 write 1 clears flag", v, 0);
    rd_at(e0 + 40, A_SA, v); check("R6 flag set again after clear", v, 16'h0008);
    rd_at(e0 + 41, A_SB, v); check("R8 no second flag after cleared first", v, 0);
    rd_at(e0 + 60, A_SB, v); check("R8 second timeout flag", v, 16'h0002);
    port_at(e0 + 62, "R9 inhibited reset_req", 0);
    wr(A_INH, 16'h0000, en);
    check("R9 reset_req not yet on inhibit edge", int'(reset_req), 0);
    port_at(en + 1, "R9 reset_req asserted", 1);
    rd_at(en + 1, A_INH, v); check("R9 inhibit reads cleared", v, 0);
    rd_at(e0 + 80, A_SB, v); check("R10 boot flag on further expiry", v, 16'h0006);
    wr(A_SB, 16'h0002, es);
    check("R9 reset_req held on clear edge", int'(reset_req), 1);
    port_at(es + 1, "R9 reset_req released", 0);
    rd_at(es + 1, A_SB, v); check("R8 second flag cleared, boot kept", v, 16'h0004);
    wr(A_SB, 16'h0004, e); rd_at(e, A_SB, v); check("R10 boot cleared", v, 0);
    wr(A_CTL, 16'h0800, eh);
    rd_at(eh, A_CTL, v); check("R3 halt readback", v, 16'h0800);
    rd_at(eh + 1, A_RLD, v);
    begin
      logic [15:0] v2;
      rd_at(eh + 40, A_RLD, v2); check("R3 halt stops count", v2, v);
      wr(A_RLD, 16'h0002, e); rd_at(e, A_RLD, v2); check("R4 non-key reload ignored", v2, v);
    end
    wr(A_RLD, 16'h0001, e); rd_at(e, A_RLD, v); check("R4 key reload", v, 5);
    wr(A_SA, 16'h0008, e);
    wr(A_INH, 16'h0001, e);
  endtask

  task automatic t_keepalive();
    logic [15:0] v; int last, e;
    wr(A_CTL, 16'h0000, last);
    for (int k = 0; k < 6; k++) begin
      while (cyc < last + 15) @(negedge clk);
      wr(A_RLD, 16'h0001, e);
      last = e;
    end
    rd_at(last, A_SA, v);      check("R2 keepalive prevents expiry", v, 0);
    rd_at(last + 19, A_SA, v); check("R2 no expiry before period after reload", v, 0);
    rd_at(last + 20, A_SA, v); check("R2 expiry one period after reload", v, 16'h0008);
    port_at(last + 22, "R9 single stage no reset", 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_config();
    t_two_stage();
    t_keepalive();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 20000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule